// File: doc/BRIEF.md
# FPU-Bit Conditional Branch Unit

This unit decides and sequences a PC-relative conditional branch whose condition is the least significant bit of a floating-point register. Each cycle it may receive one instruction word with a valid flag. Alongside the word it receives the address of that instruction, bit 0 of the floating-point register that the instruction names, and a flag that says whether the floating-point coprocessor may be used. From these it produces the address of the next instruction, a flag that marks a redirect being applied, and two exception flags. Only the least significant register bit can influence the decision, so the branch behaves the same whatever format produced the register value.

The branch has one delay slot. The instruction that follows a branch always executes. If the condition held, the redirect to the target is applied when that delay-slot instruction is presented, so the instruction after the slot is fetched from the target. A control transfer that sits in the delay slot is reported as a reserved-instruction fault. A branch issued while the coprocessor is disabled is reported as a coprocessor-unusable fault. In both cases nothing is redirected. The unit reports exceptions only; vectoring to a handler is done elsewhere.

Top module: `fbr_unit`

## Requirements
- R1: An instruction is a branch only when bits [31:26] are 010001 and bits [25:21] are either 01001 (branch-if-clear form) or 01101 (branch-if-set form). Every other value of bits [25:21] under that opcode is an ordinary instruction.
- R2: The branch-if-clear form is taken only when `fpr_lsb_i` is 0, and the branch-if-set form only when it is 1. Bits [20:16], the register selector, have no effect on the decision.
- R3: The target equals (PC + 4) plus bits [15:0] shifted left by two and sign-extended from 18 bits, computed modulo 2^32.
- R4: In the cycle of an accepted branch, `next_pc_o` is PC + 4 and `redirect_o` is 0. If the branch is taken, the next valid instruction (the delay slot) shows `next_pc_o` equal to the target and `redirect_o` equal to 1.
- R5: If the branch is not taken, the delay-slot instruction shows `next_pc_o` equal to its own PC + 4 and `redirect_o` equal to 0.
- R6: A branch presented with `cop1_en_i` low raises `cop_unusable_o` for that cycle, gives `next_pc_o` = PC + 4, and leaves no pending redirect.
- R7: If the delay-slot instruction is a control transfer, `reserved_instr_o` is raised, `redirect_o` is 0, `next_pc_o` is PC + 4, and all pending state is dropped. Control transfers are: opcode 000001, 000010, 000011, or 0001xx; opcode 000000 with function 001000 or 001001; either form from R1; opcode 010000 with bit 25 set and function 011000, 011111 or 100000; and the word 0x00000140.
- R8: Any instruction that is neither a branch nor a delay slot gives `next_pc_o` = PC + 4, with `redirect_o` and both exception flags low.
- R9: Cycles with `instr_valid_i` low raise no flag and leave the pending state unchanged, so a redirect waits for the next valid instruction.
- R10: A synchronous reset clears the delay-slot tracking and the pending target, so the first instruction after reset is never redirected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the presented instruction |
| fpr_lsb_i | input | 1 | Bit 0 of the floating-point register selected by the instruction |
| cop1_en_i | input | 1 | Floating-point coprocessor access is enabled |
| next_pc_o | output | 32 | Address of the next instruction to fetch |
| redirect_o | output | 1 | A taken branch's target is being applied this cycle |
| cop_unusable_o | output | 1 | Branch attempted with the coprocessor disabled |
| reserved_instr_o | output | 1 | Control transfer found in a delay slot |

## Verification
Every output is combinational in the presented instruction and the registered pending state. The exception flags, and the PC + 4 result in a branch cycle, belong to the same cycle as their stimulus. A taken branch's redirect is due on the next cycle whose valid flag is high, which may be several clock edges later when idle cycles come between. The bench drives each input set after a falling edge and compares all four outputs against a behavioural model one time unit later, before the rising edge. It updates the model's pending state only after that comparison, so the redirect is checked against the instruction that actually follows the branch.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    localparam int ADDR_W    = 32;
    localparam int INSTR_W   = 32;
    localparam int OFF_W     = 16;
    localparam int OFF_SHIFT = 2;

    localparam logic [5:0] OP_COP1    = 6'b010001;
    localparam logic [5:0] OP_COP0    = 6'b010000;
    localparam logic [5:0] OP_SPECIAL = 6'b000000;
    localparam logic [4:0] SUB_CLEAR  = 5'b01001;
    localparam logic [4:0] SUB_SET    = 5'b01101;

    typedef enum logic [1:0] {
        BK_NONE  = 2'd0,
        BK_CLEAR = 2'd1,
        BK_SET   = 2'd2
    } br_kind_e;

    typedef struct packed {
        br_kind_e          kind;
        logic              is_xfer;
        logic [4:0]        reg_sel;
        logic [OFF_W-1:0]  offset;
    } dec_t;

    typedef struct packed {
        logic              slot;
        logic              take;
        logic [ADDR_W-1:0] target;
    } pend_t;

    function automatic br_kind_e branch_kind(input logic [INSTR_W-1:0] w);
        br_kind_e k;
        k = BK_NONE;
        if (w[31:26] == OP_COP1) begin
            if (w[25:21] == SUB_CLEAR)
                k = BK_CLEAR;
            else if (w[25:21] == SUB_SET)
                k = BK_SET;
        end
        return k;
    endfunction

    function automatic logic is_control_xfer(input logic [INSTR_W-1:0] w);
        logic [5:0] op;
        logic [5:0] fn;
        logic       hit;
        op  = w[31:26];
        fn  = w[5:0];
        hit = 1'b0;
        if (op == 6'b000001 || op == 6'b000010 || op == 6'b000011)
            hit = 1'b1;
        if (op[5:2] == 4'b0001)
            hit = 1'b1;
        if (op == OP_SPECIAL && (fn == 6'b001000 || fn == 6'b001001))
            hit = 1'b1;
        if (branch_kind(w) != BK_NONE)
            hit = 1'b1;
        if (op == OP_COP0 && w[25] &&
            (fn == 6'b011000 || fn == 6'b011111 || fn == 6'b100000))
            hit = 1'b1;
        if (w == 32'h0000_0140)
            hit = 1'b1;
        return hit;
    endfunction

    function automatic logic cond_met(input br_kind_e k, input logic lsb);
        return (k == BK_CLEAR) ? ~lsb : ((k == BK_SET) ? lsb : 1'b0);
    endfunction

endpackage

// File: rtl/fbr_decode.sv
module fbr_decode
    import fbr_pkg::*;
#(
    parameter int IW = INSTR_W
) (
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    always_comb begin
        dec.kind    = branch_kind(instr);
        dec.is_xfer = is_control_xfer(instr);
        dec.reg_sel = instr[20:16];
        dec.offset  = instr[OFF_W-1:0];
    end
endmodule

// File: rtl/fbr_target.sv
module fbr_target
    import fbr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OFF_W,
    parameter int SH = OFF_SHIFT
) (
    input  logic [AW-1:0] pc,
    input  logic [OW-1:0] offset,
    output logic [AW-1:0] link,
    output logic [AW-1:0] target
);
    localparam int SW = OW + SH;

    logic [SW-1:0] scaled;
    logic [AW-1:0] disp;

    always_comb begin
        scaled = {offset, {SH{1'b0}}};
        disp   = {{(AW-SW){scaled[SW-1]}}, scaled};
        link   = pc + AW'(4);
        target = link + disp;
    end
endmodule

// File: rtl/fbr_seq.sv
module fbr_seq
    import fbr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  dec_t          dec,
    input  logic          fpr_lsb,
    input  logic          cop_en,
    input  logic [AW-1:0] link,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] next_pc,
    output logic          redirect,
    output logic          cu_exc,
    output logic          ri_exc
);
    pend_t pq, pd;

    always_comb begin
        pd       = pq;
        next_pc  = link;
        redirect = 1'b0;
        cu_exc   = 1'b0;
        ri_exc   = 1'b0;
        if (valid) begin
            if (pq.slot) begin
                pd.slot = 1'b0;
                pd.take = 1'b0;
                if (dec.is_xfer) begin
                    ri_exc = 1'b1;
                end else if (pq.take) begin
                    redirect = 1'b1;
                    next_pc  = pq.target;
                end
            end else if (dec.kind != BK_NONE) begin
                if (!cop_en) begin
                    cu_exc = 1'b1;
                end else begin
                    pd.slot   = 1'b1;
                    pd.take   = cond_met(dec.kind, fpr_lsb);
                    pd.target = target;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pq <= '0;
        end else begin
            pq <= pd;
        end
    end

    AST_REDIRECT_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        redirect |-> pq.slot && pq.take) else $error("redirect outside slot"); // R4
    AST_SLOT_FOLLOWS_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (valid && !pq.slot && dec.kind != BK_NONE && cop_en) |=> pq.slot) else $error("slot not armed"); // R4
    AST_NO_REDIRECT_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        (cu_exc || ri_exc) |-> !redirect) else $error("redirect with fault"); // R7
    AST_FAULT_CLEARS_SLOT: assert property (@(posedge clk) disable iff (rst)
        (valid && ri_exc) |=> !pq.slot && !pq.take) else $error("slot kept after fault"); // R7
    AST_CU_NO_TRACK: assert property (@(posedge clk) disable iff (rst)
        (valid && cu_exc) |=> !pq.slot) else $error("slot armed when disabled"); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(pq)) else $error("state moved on idle"); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !cu_exc && !ri_exc && !redirect) else $error("flag on idle"); // R9
endmodule

// File: rtl/fbr_unit.sv
module fbr_unit
    import fbr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = INSTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid_i,
    input  logic [IW-1:0] instr_i,
    input  logic [AW-1:0] pc_i,
    input  logic          fpr_lsb_i,
    input  logic          cop1_en_i,
    output logic [AW-1:0] next_pc_o,
    output logic          redirect_o,
    output logic          cop_unusable_o,
    output logic          reserved_instr_o
);
    dec_t          dec;
    logic [AW-1:0] link;
    logic [AW-1:0] target;

    fbr_decode #(.IW(IW)) u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    fbr_target #(.AW(AW), .OW(OFF_W), .SH(OFF_SHIFT)) u_tgt (
        .pc     (pc_i),
        .offset (dec.offset),
        .link   (link),
        .target (target)
    );

    fbr_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .valid    (instr_valid_i),
        .dec      (dec),
        .fpr_lsb  (fpr_lsb_i),
        .cop_en   (cop1_en_i),
        .link     (link),
        .target   (target),
        .next_pc  (next_pc_o),
        .redirect (redirect_o),
        .cu_exc   (cop_unusable_o),
        .ri_exc   (reserved_instr_o)
    );

    AST_SEQUENTIAL_PC: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && !redirect_o) |-> next_pc_o == pc_i + AW'(4)) else $error("bad sequential pc"); // R8
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
        !(cop_unusable_o && reserved_instr_o)) else $error("two faults"); // R7
endmodule

// File: tb/fbr_unit_tb.sv
module fbr_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic [31:0] ins = '0;
    logic [31:0] pc  = '0;
    logic        lsb = 1'b0;
    logic        en  = 1'b1;
    logic [31:0] npc;
    logic        rdr, cu, ri;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    bit          m_slot = 0;
    bit          m_take = 0;
    logic [31:0] m_tgt  = '0;

    always #5 clk = ~clk;

    fbr_unit u_dut (
        .clk(clk), .rst(rst), .instr_valid_i(vld), .instr_i(ins), .pc_i(pc),
        .fpr_lsb_i(lsb), .cop1_en_i(en), .next_pc_o(npc), .redirect_o(rdr),
        .cop_unusable_o(cu), .reserved_instr_o(ri)
    );

    function automatic int kind_of(input logic [31:0] w);
        if (w[31:26] != 6'o21) return 0;
        case (w[25:21])
            5'd9:    return 1;
            5'd13:   return 2;
            default: return 0;
        endcase
    endfunction

    function automatic bit xfer(input logic [31:0] w);
        case (w[31:26])
            6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7: return 1;
            6'd0:  return (w[5:0] == 6'd8 || w[5:0] == 6'd9 || w == 32'd320);
            6'd16: return w[25] && (w[5:0] == 6'd24 || w[5:0] == 6'd31 || w[5:0] == 6'd32);
            6'd17: return kind_of(w) != 0;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] w, input logic [31:0] p,
                        input bit b, input bit e, input string tag);
        logic [31:0] e_npc;
        bit e_rdr, e_cu, e_ri;
        int k;
        @(negedge clk);
        vld = v; ins = w; pc = p; lsb = b; en = e;
        e_npc = p + 32'd4; e_rdr = 0; e_cu = 0; e_ri = 0;
        k = kind_of(w);
        if (v) begin
            if (m_slot) begin
                if (xfer(w)) e_ri = 1;
                else if (m_take) begin e_rdr = 1; e_npc = m_tgt; end
                m_slot = 0; m_take = 0;
            end else if (k != 0) begin
                if (!e) e_cu = 1;
                else begin
                    m_slot = 1;
                    m_take = (k == 1) ? !b : b;
                    m_tgt  = p + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
                end
            end
        end
        #1;
        chk(tag, "next_pc", npc, e_npc);
        chk(tag, "redirect", {31'd0, rdr}, {31'd0, e_rdr});
        chk(tag, "cop_unusable", {31'd0, cu}, {31'd0, e_cu});
        chk(tag, "reserved_instr", {31'd0, ri}, {31'd0, e_ri});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vld = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_slot = 0; m_take = 0; m_tgt = '0;
    endtask

    function automatic logic [31:0] br(input bit set, input logic [4:0] ft, input logic [15:0] off);
        return {6'b010001, set ? 5'b01101 : 5'b01001, ft, off};
    endfunction

    localparam logic [31:0] NOP = 32'h0000_0000;
    localparam logic [31:0] ALU = 32'h0123_4020;

    function automatic logic [31:0] rand_word();
        int sel;
        sel = $urandom_range(0, 9);
        case (sel)
            0, 1, 2: return br($urandom_range(0, 1), 5'($urandom), 16'($urandom));
            3: return {6'd2, 26'($urandom)};
            4: return {6'd16, 1'b1, 19'($urandom), 6'd24};
            5: return {6'd0, 20'($urandom), 6'd8};
            6: return 32'h0000_0140;
            7: return {6'b010001, 5'b01000, 21'($urandom)};
            default: return {6'b001001, 26'($urandom)};
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state, first instruction not redirected
        step(1, NOP, 32'h100, 0, 1, "R10");
        // R1 R2 R4: branch-if-clear taken with lsb 0
        step(1, br(0, 5'd3, 16'h0010), 32'h1000, 0, 1, "R4");
        step(1, ALU, 32'h1004, 1, 1, "R4");
        step(1, NOP, 32'h1044, 0, 1, "R8");
        // R2: branch-if-set taken with lsb 1, ft changed
        step(1, br(1, 5'd31, 16'h0002), 32'h2000, 1, 1, "R2");
        step(1, NOP, 32'h2004, 0, 1, "R2");
        // R5: not taken
        step(1, br(1, 5'd7, 16'h0040), 32'h3000, 0, 1, "R5");
        step(1, ALU, 32'h3004, 1, 1, "R5");
        step(1, br(0, 5'd7, 16'h0040), 32'h3008, 1, 1, "R5");
        step(1, NOP, 32'h300C, 0, 1, "R5");
        // R3: negative offset and wrap
        step(1, br(0, 5'd1, 16'hFFFC), 32'h4000, 0, 1, "R3");
        step(1, NOP, 32'h4004, 0, 1, "R3");
        step(1, br(1, 5'd1, 16'h0001), 32'hFFFF_FFFC, 1, 1, "R3");
        step(1, NOP, 32'h0000_0000, 0, 1, "R3");
        step(1, br(1, 5'd1, 16'h8000), 32'h0000_0010, 1, 1, "R3");
        step(1, NOP, 32'h0000_0014, 0, 1, "R3");
        // R6: coprocessor disabled
        step(1, br(0, 5'd2, 16'h0100), 32'h5000, 0, 0, "R6");
        step(1, NOP, 32'h5004, 0, 1, "R6");
        // R7: transfers in delay slot
        step(1, br(0, 5'd2, 16'h0100), 32'h6000, 0, 1, "R7");
        step(1, {6'd2, 26'h12345}, 32'h6004, 0, 1, "R7");
        step(1, NOP, 32'h6008, 0, 1, "R7");
        step(1, br(1, 5'd2, 16'h0100), 32'h6100, 1, 1, "R7");
        step(1, br(0, 5'd2, 16'h0020), 32'h6104, 0, 1, "R7");
        step(1, NOP, 32'h6108, 0, 1, "R7");
        step(1, br(1, 5'd2, 16'h0100), 32'h6200, 1, 1, "R7");
        step(1, 32'h4200_0018, 32'h6204, 0, 1, "R7");
        step(1, br(1, 5'd2, 16'h0100), 32'h6300, 1, 1, "R7");
        step(1, 32'h0000_0140, 32'h6304, 0, 1, "R7");
        // R1: other sub-field under the opcode is ordinary
        step(1, {6'b010001, 5'b01000, 21'h1F_0010}, 32'h7000, 0, 1, "R1");
        step(1, NOP, 32'h7004, 0, 1, "R1");
        // R9: idle cycles between branch and slot
        step(1, br(0, 5'd4, 16'h0008), 32'h8000, 0, 1, "R9");
        step(0, br(1, 5'd4, 16'h0001), 32'h9990, 1, 0, "R9");
        step(0, 32'h0800_0000, 32'h9994, 0, 1, "R9");
        step(1, ALU, 32'h8004, 0, 1, "R9");
        // R10: reset drops a pending redirect
        step(1, br(0, 5'd4, 16'h0008), 32'hA000, 0, 1, "R10");
        do_reset();
        step(1, NOP, 32'hA004, 0, 1, "R10");
        // mixed traffic against the model
        for (int i = 0; i < 2000; i++) begin
            step($urandom_range(0, 5) != 0, rand_word(), 32'($urandom) & 32'hFFFF_FFFC,
                 1'($urandom), $urandom_range(0, 7) != 0, "R8");
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule